// File: doc/BRIEF.md
# Chip-Enable Register Bank

This block holds a small set of software-visible registers behind the simplified user-side interface that a bus adapter presents once it has done the address decoding. The adapter raises one bit of a one-hot write-enable or read-enable vector for the register it targets. Write data comes in on its own bus, together with one byte-enable bit per 8-bit lane. Read data goes out on a separate bus. There is no bidirectional data signal.

Writes update only the lanes whose byte enable is set. Reads return the contents of the selected register. Each acknowledge is the OR of its enable vector, so an access completes in the cycle it is presented. The acknowledge drops as soon as the adapter removes the enable. Any enable pattern is acknowledged, including one with no byte lanes set or with several enable bits set. Such a transaction ends cleanly and changes nothing. All register contents are also driven out on a flat port for the user logic behind the bank.

Top module: `ce_regbank`

## Requirements
- R1: A synchronous active-high reset clears every register to zero.
- R2: Register k is selected by enable bit NREG-1-k, so the most significant bit maps to register 0. With three registers, the pattern 100 targets register 0, 010 targets register 1 and 001 targets register 2.
- R3: During a selected write, byte lane l (bits 8l+7..8l) of the target register takes the value of the same lane of wdata at the clock edge only if byte_en[l] is 1. All other lanes keep their value.
- R4: wr_ack is high in exactly the cycles in which any wr_ce bit is high. This holds whatever byte_en is, and wr_ack goes low in the same cycle the enables drop.
- R5: A write with byte_en all zero is acknowledged and leaves every register unchanged.
- R6: rd_ack is high in exactly the cycles in which any rd_ce bit is high.
- R7: While a single rd_ce bit is set, rdata equals the selected register in that same cycle. While no rd_ce bit is set, rdata is zero.
- R8: A wr_ce vector with two or more bits set changes no register but is still acknowledged.
- R9: A rd_ce vector with two or more bits set returns zero on rdata but is still acknowledged.
- R10: Registers that are not selected by a write keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_ce | input | NREG | One-hot write enable; MSB selects register 0 |
| rd_ce | input | NREG | One-hot read enable; MSB selects register 0 |
| byte_en | input | DATA_W/8 | Per-lane write enable |
| wdata | input | DATA_W | Inbound write data |
| rdata | output | DATA_W | Outbound read data, valid while rd_ack is high |
| wr_ack | output | 1 | Write acknowledge, same cycle |
| rd_ack | output | 1 | Read acknowledge, same cycle |
| regs_q | output | NREG*DATA_W | All registers; register k at bits k*DATA_W and up |

## Verification
The assertions assume that the enable and data inputs are settled before each rising edge and that nothing is expected of the bank while reset is high. They make no assumption that the enables are one-hot, because multi-bit and all-zero vectors are legal and have defined results. The stimulus changes every input only on the falling edge. Most random enable vectors are one-hot, with some all-zero and multi-bit vectors mixed in. Random byte-enable masks, including all-zero and all-one masks, cover both the no-op and the full-width write paths.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    typedef struct packed {
        logic any;     // at least one enable bit set
        logic single;  // exactly one enable bit set
    } ce_info_t;

    // true when exactly one bit of v is set
    function automatic logic is_single(input logic [31:0] v);
        return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
    endfunction

    function automatic ce_info_t classify(input logic [31:0] v);
        ce_info_t r;
        r.any    = (v != 32'd0);
        r.single = is_single(v);
        return r;
    endfunction

endpackage

// File: rtl/regbank_ce_decode.sv
module regbank_ce_decode
    import regbank_pkg::*;
#(
    parameter int NREG = 3
) (
    input  logic [NREG-1:0] ce,
    output logic [NREG-1:0] sel,
    output logic            ack
);
    ce_info_t info;

    always_comb begin
        info = classify(32'(ce));
        ack  = info.any;
    end

    // register k answers to enable bit NREG-1-k
    for (genvar k = 0; k < NREG; k++) begin : g_sel
        assign sel[k] = info.single & ce[NREG-1-k];
    end

endmodule

// File: rtl/regbank_lane_reg.sv
module regbank_lane_reg #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                q[l*8 +: 8] <= 8'h00;
            else if (sel && be[l])
                q[l*8 +: 8] <= wdata[l*8 +: 8];
        end

        // R3 / R10: a lane moves only when selected and enabled
        a_r3_lane_hold: assert property (@(posedge clk) disable iff (rst)
            !(sel && be[l]) |=> $stable(q[l*8 +: 8]));

        // R3: an enabled lane captures the inbound data
        a_r3_lane_load: assert property (@(posedge clk) disable iff (rst)
            (sel && be[l]) |=> (q[l*8 +: 8] == $past(wdata[l*8 +: 8])));
    end

endmodule

// File: rtl/regbank_rd_mux.sv
module regbank_rd_mux #(
    parameter int DATA_W = 32,
    parameter int NREG   = 3
) (
    input  logic [NREG-1:0]        sel,
    input  logic [NREG*DATA_W-1:0] regs,
    output logic [DATA_W-1:0]      rdata
);
    // sel is at most one-hot, so an AND-OR tree is a clean mux
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NREG; k++)
            rdata = rdata | (regs[k*DATA_W +: DATA_W] & {DATA_W{sel[k]}});
    end

endmodule

// File: rtl/ce_regbank.sv
module ce_regbank #(
    parameter int DATA_W = 32,
    parameter int NREG   = 3,
    localparam int LANES = DATA_W / 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NREG-1:0]        wr_ce,
    input  logic [NREG-1:0]        rd_ce,
    input  logic [LANES-1:0]       byte_en,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic                   wr_ack,
    output logic                   rd_ack,
    output logic [NREG*DATA_W-1:0] regs_q
);
    logic [NREG-1:0] wsel;
    logic [NREG-1:0] rsel;

    regbank_ce_decode #(.NREG(NREG)) u_wdec (
        .ce(wr_ce), .sel(wsel), .ack(wr_ack)
    );

    regbank_ce_decode #(.NREG(NREG)) u_rdec (
        .ce(rd_ce), .sel(rsel), .ack(rd_ack)
    );

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        regbank_lane_reg #(.DATA_W(DATA_W)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .sel   (wsel[k]),
            .be    (byte_en),
            .wdata (wdata),
            .q     (regs_q[k*DATA_W +: DATA_W])
        );
    end

    regbank_rd_mux #(.DATA_W(DATA_W), .NREG(NREG)) u_rmux (
        .sel   (rsel),
        .regs  (regs_q),
        .rdata (rdata)
    );

    // R5: a write with no byte lane enabled leaves the bank untouched
    a_r5_empty_mask_hold: assert property (@(posedge clk) disable iff (rst)
        (byte_en == '0) |=> $stable(regs_q));

    // R8: multi-bit write enables are acknowledged but change nothing
    a_r8_multi_wr_hold: assert property (@(posedge clk) disable iff (rst)
        ($countones(wr_ce) > 1) |-> ##1 $stable(regs_q));

    a_r8_multi_wr_ack: assert property (@(posedge clk) disable iff (rst)
        ($countones(wr_ce) > 1) |-> wr_ack);

    // R9: multi-bit read enables return zero with an acknowledge
    a_r9_multi_rd_zero: assert property (@(posedge clk) disable iff (rst)
        ($countones(rd_ce) > 1) |-> (rd_ack && rdata == '0));

    // R7: idle read path drives zero
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_ce == '0) |-> (rdata == '0 && !rd_ack));

    // R10: without any write enable, no register moves
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_ack |=> $stable(regs_q));

    // R4: acknowledges never appear without an enable
    a_r4_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_ce) && (wr_ce == '0) |-> !wr_ack);

endmodule

// File: tb/sim_ce_regbank.sv
module sim_ce_regbank;
    localparam int DW = 32;
    localparam int NR = 3;
    localparam int NL = DW / 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NR-1:0]  wr_ce = '0;
    logic [NR-1:0]  rd_ce = '0;
    logic [NL-1:0]  byte_en = '0;
    logic [DW-1:0]  wdata = '0;
    logic [DW-1:0]  rdata;
    logic           wr_ack;
    logic           rd_ack;
    logic [NR*DW-1:0] regs_q;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [NR];

    always #2 clk = ~clk;

    ce_regbank #(.DATA_W(DW), .NREG(NR)) u0 (
        .clk(clk), .rst(rst), .wr_ce(wr_ce), .rd_ce(rd_ce),
        .byte_en(byte_en), .wdata(wdata), .rdata(rdata),
        .wr_ack(wr_ack), .rd_ack(rd_ack), .regs_q(regs_q)
    );

    task automatic chk(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic single(input logic [NR-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [NL-1:0] be);
        logic [DW-1:0] r = old;
        for (int l = 0; l < NL; l++)
            if (be[l]) r[l*8 +: 8] = nw[l*8 +: 8];
        return r;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [NR-1:0] ce);
        logic [DW-1:0] r = '0;
        if (single(ce))
            for (int k = 0; k < NR; k++)
                if (ce[NR-1-k]) r = model[k];
        return r;
    endfunction

    task automatic check_regs(input string req);
        for (int k = 0; k < NR; k++)
            chk(req, regs_q[k*DW +: DW], model[k]);
    endtask

    // drive on falling edge, check ack mid-low, commit at rising edge
    task automatic do_write(input logic [NR-1:0] ce, input logic [NL-1:0] be,
                            input logic [DW-1:0] d, input string req);
        @(negedge clk);
        wr_ce = ce; byte_en = be; wdata = d;
        #1;
        chk({req, " R4 wr_ack"}, DW'(wr_ack), DW'(ce != '0));
        @(posedge clk);
        if (single(ce))
            for (int k = 0; k < NR; k++)
                if (ce[NR-1-k]) model[k] = merge(model[k], d, be);
        @(negedge clk);
        wr_ce = '0; byte_en = '0;
        #1;
        chk("R4 wr_ack drop", DW'(wr_ack), '0);
        check_regs({req, " R10 regs"});
    endtask

    task automatic do_read(input logic [NR-1:0] ce, input string req);
        @(negedge clk);
        rd_ce = ce;
        #1;
        chk({req, " R6 rd_ack"}, DW'(rd_ack), DW'(ce != '0));
        chk({req, " R7 rdata"}, rdata, exp_read(ce));
        @(negedge clk);
        rd_ce = '0;
    endtask

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [NR-1:0] ce;
        void'($urandom(32'h1234_abcd));
        for (int k = 0; k < NR; k++) model[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_regs("R1 reset");
        chk("R1 R7 idle rdata", rdata, '0);

        // R2 mapping: MSB is register 0
        do_write(3'b100, 4'hF, 32'h1111_1111, "R2 reg0");
        do_write(3'b010, 4'hF, 32'h2222_2222, "R2 reg1");
        do_write(3'b001, 4'hF, 32'h3333_3333, "R2 reg2");
        do_read(3'b100, "R2 rd0");
        do_read(3'b010, "R2 rd1");
        do_read(3'b001, "R2 rd2");
        // R3 partial lanes
        do_write(3'b010, 4'b0101, 32'hAABB_CCDD, "R3 lanes");
        do_read(3'b010, "R3 rd");
        // R5 empty mask
        do_write(3'b100, 4'b0000, 32'hFFFF_FFFF, "R5 empty");
        // R8 multi-bit write
        do_write(3'b110, 4'hF, 32'hDEAD_BEEF, "R8 multi");
        do_write(3'b111, 4'hF, 32'hDEAD_BEEF, "R8 all");
        // R9 multi-bit read, R7 idle read
        do_read(3'b101, "R9 multi");
        do_read(3'b000, "R7 idle");

        for (int i = 0; i < 400; i++) begin
            case ($urandom_range(0, 9))
                0:       ce = NR'($urandom);
                1:       ce = '0;
                default: ce = NR'(1) << $urandom_range(0, NR - 1);
            endcase
            if ($urandom_range(0, 1) == 0)
                do_write(ce, NL'($urandom), $urandom, "rand R3");
            else
                do_read(ce, "rand R7");
        end

        // R1 again: reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int k = 0; k < NR; k++) model[k] = '0;
        #1;
        check_regs("R1 rereset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule